// File: doc/BRIEF.md
# Serial Transmit Path with Occupancy Watermark

This block is the sending half of a small memory-mapped serial port. Software writes bytes through a register-style write port, and each byte enters an eight-entry queue. A serializer takes bytes from the head of the queue and sends each one as an asynchronous frame on a single line that stays high when idle. A frame has one low start bit, eight data bits sent least significant first, and one or two high stop bits. A shared 16-bit divisor sets the bit time.

Software polls a status word whose top bit shows that the queue is full. It can also wait for an interrupt, which is raised while the queue holds fewer bytes than a programmable 3-bit level. When the level is 1, the pending flag comes up as soon as the queue is empty, while the last frame is still leaving the serializer. The control word carries the run enable in bit 0, the stop-bit choice in bit 1 and the watermark level in bits 18:16.

Top module: `uart_tx_wm`

## Requirements
- R1: While reset is held and directly after it, `txd` is 1, the queue is empty and `rd_data` reads all zeros.
- R2: A frame is a 0 start bit, then data bits 0 to 7 in that order, then high stop time. Every bit lasts `divisor`+1 clock cycles, with `divisor` = 0 giving one-cycle bits.
- R3: When `ctrl[1]` is 0 the frame has one stop bit. When it is 1 the frame has two stop bits.
- R4: A cycle with `wr_en` high and the queue not full appends `wr_data[7:0]` to the queue. The queue holds at most 8 bytes, and bytes leave in the order they were written.
- R5: `rd_data[31]` is 1 exactly while the queue holds 8 bytes. Bits 30:0 always read 0.
- R6: A write made while the queue is full is dropped, and the queued bytes and their order are left unchanged.
- R7: `wm_pending` is 1 exactly while the queue occupancy is strictly less than `ctrl[18:16]`. A level of 0 never raises it.
- R8: `irq` equals `wm_pending` AND `int_en`.
- R9: With level 1, `wm_pending` rises in the cycle the last queued byte is taken, while that byte's frame is still being sent.
- R10: While `ctrl[0]` is 0, no new frame starts and queued bytes stay queued. Clearing `ctrl[0]` during a frame lets that frame finish.
- R11: While enabled with bytes queued, the next start bit directly follows the previous frame's last stop bit, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 32 | Write word; bits 7:0 hold the byte |
| rd_data | output | 32 | Status word; bit 31 is the queue-full flag |
| ctrl | input | 32 | Bit 0 enable, bit 1 two stop bits, bits 18:16 watermark level |
| int_en | input | 1 | Watermark interrupt enable |
| divisor | input | 16 | Bit time minus one, in clocks |
| txd | output | 1 | Serial output, idles high |
| wm_pending | output | 1 | Watermark pending flag |
| irq | output | 1 | Gated interrupt request |

## Verification
The bench drives four kinds of traffic: single bytes with gaps between them, writes on every cycle that overrun the queue while sending is paused, long runs of queued bytes with divisor 0 and with divisor 3, and an enable cleared in the middle of a frame. Single bytes confirm bit order and bit length, and they separate the one-stop and two-stop frame lengths. Overrun bursts show whether the ninth and later writes are dropped and whether the full flag is exact. Long runs reveal any idle cycle inserted between frames. Sweeping the watermark level while the queue drains separates a strict less-than comparison from an off-by-one one, and it places the rise of the pending flag against the frame still being sent.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_START = 2'd1,
        SER_DATA  = 2'd2,
        SER_STOP  = 2'd3
    } ser_state_e;

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DW-1:0]                din,
    input  logic                         pop,
    output logic [DW-1:0]                dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wptr;
        logic [AW-1:0]            rptr;
        logic [CW-1:0]            cnt;
    } fifo_t;

    fifo_t s_q, s_d;
    logic  push_ok, pop_ok;

    assign full    = (s_q.cnt == CW'(DEPTH));
    assign empty   = (s_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_comb begin
        s_d = s_q;
        if (push_ok) begin
            s_d.mem[s_q.wptr] = din;
            s_d.wptr          = (s_q.wptr == AW'(DEPTH-1)) ? '0 : s_q.wptr + 1'b1;
        end
        if (pop_ok) begin
            s_d.rptr = (s_q.rptr == AW'(DEPTH-1)) ? '0 : s_q.rptr + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout  = s_q.mem[s_q.rptr];
    assign count = s_q.cnt;
endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser
    import uart_tx_pkg::*;
#(
    parameter int DW   = 8,
    parameter int DIVW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            two_stop,
    input  logic [DIVW-1:0] divisor,
    input  logic            avail,
    input  logic [DW-1:0]   head,
    output logic            take,
    output logic            txd,
    output logic            busy
);
    localparam int IW = $clog2(DW);

    typedef struct packed {
        ser_state_e      st;
        logic [DIVW-1:0] cnt;
        logic [IW-1:0]   idx;
        logic            sbit;
        logic [DW-1:0]   sh;
        logic            txd;
    } ser_t;

    ser_t s_q, s_d;

    always_comb begin
        s_d  = s_q;
        take = 1'b0;
        if (s_q.st == SER_IDLE) begin
            if (en && avail) begin
                take      = 1'b1;
                s_d.sh    = head;
                s_d.st    = SER_START;
                s_d.cnt   = '0;
                s_d.txd   = 1'b0;
            end else begin
                s_d.txd   = 1'b1;
            end
        end else if (s_q.cnt == divisor) begin
            s_d.cnt = '0;
            case (s_q.st)
                SER_START: begin
                    s_d.st  = SER_DATA;
                    s_d.idx = '0;
                    s_d.txd = s_q.sh[0];
                end
                SER_DATA: begin
                    if (s_q.idx == IW'(DW-1)) begin
                        s_d.st   = SER_STOP;
                        s_d.sbit = 1'b0;
                        s_d.txd  = 1'b1;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                        s_d.sh  = s_q.sh >> 1;
                        s_d.txd = s_q.sh[1];
                    end
                end
                default: begin
                    if (two_stop && !s_q.sbit) begin
                        s_d.sbit = 1'b1;
                        s_d.txd  = 1'b1;
                    end else if (en && avail) begin
                        take     = 1'b1;
                        s_d.sh   = head;
                        s_d.st   = SER_START;
                        s_d.txd  = 1'b0;
                    end else begin
                        s_d.st   = SER_IDLE;
                        s_d.txd  = 1'b1;
                    end
                end
            endcase
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.st  <= SER_IDLE;
            s_q.txd <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign txd  = s_q.txd;
    assign busy = (s_q.st != SER_IDLE);
endmodule

// File: rtl/uart_tx_wmark.sv
module uart_tx_wmark #(
    parameter int CW = 4,
    parameter int LW = 3
) (
    input  logic [CW-1:0] count,
    input  logic [LW-1:0] level,
    input  logic          int_en,
    output logic          pending,
    output logic          irq
);
    localparam int XW = (CW > LW) ? CW : LW;

    always_comb begin
        pending = (XW'(count) < XW'(level));
        irq     = pending && int_en;
    end
endmodule

// File: rtl/uart_tx_wm.sv
module uart_tx_wm #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int DIVW  = 16,
    parameter int LW    = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [31:0]     wr_data,
    output logic [31:0]     rd_data,
    input  logic [31:0]     ctrl,
    input  logic            int_en,
    input  logic [DIVW-1:0] divisor,
    output logic            txd,
    output logic            wm_pending,
    output logic            irq
);
    localparam int CW       = $clog2(DEPTH+1);
    localparam int EN_BIT   = 0;
    localparam int STOP_BIT = 1;
    localparam int LVL_LO   = 16;
    localparam int FULL_BIT = 31;

    logic [DW-1:0] fifo_head;
    logic [CW-1:0] fifo_count;
    logic          fifo_full, fifo_empty;
    logic          ser_take, ser_busy;
    logic [LW-1:0] wm_level;
    logic          unused_bits;

    assign wm_level    = ctrl[LVL_LO +: LW];
    assign unused_bits = ^{wr_data[31:DW], ctrl[31:LVL_LO+LW], ctrl[LVL_LO-1:STOP_BIT+1]};

    uart_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_en),
        .din   (wr_data[DW-1:0]),
        .pop   (ser_take),
        .dout  (fifo_head),
        .count (fifo_count),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    uart_tx_ser #(.DW(DW), .DIVW(DIVW)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl[EN_BIT]),
        .two_stop (ctrl[STOP_BIT]),
        .divisor  (divisor),
        .avail    (!fifo_empty),
        .head     (fifo_head),
        .take     (ser_take),
        .txd      (txd),
        .busy     (ser_busy)
    );

    uart_tx_wmark #(.CW(CW), .LW(LW)) u_wm (
        .count   (fifo_count),
        .level   (wm_level),
        .int_en  (int_en),
        .pending (wm_pending),
        .irq     (irq)
    );

    always_comb begin
        rd_data           = '0;
        rd_data[FULL_BIT] = fifo_full;
    end
endmodule

// File: rtl/uart_tx_wm_chk.sv
module uart_tx_wm_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4,
    parameter int LW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          full,
    input logic          pop,
    input logic [CW-1:0] count,
    input logic          txd,
    input logic          busy,
    input logic          en,
    input logic          ie,
    input logic          irq,
    input logic          pending,
    input logic [LW-1:0] level
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R4
    AST_WRITE_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full && !pop) |=> (count == $past(count) + 1'b1)); // R4
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !pop) |=> (count == $past(count))); // R6
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd); // R2
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd); // R1
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !busy) |=> !busy); // R10
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie); // R8
    AST_EMPTY_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && level != '0) |-> pending); // R7
endmodule

bind uart_tx_wm uart_tx_wm_chk #(.DEPTH(DEPTH), .CW(CW), .LW(LW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .full    (fifo_full),
    .pop     (ser_take),
    .count   (fifo_count),
    .txd     (txd),
    .busy    (ser_busy),
    .en      (ctrl[0]),
    .ie      (int_en),
    .irq     (irq),
    .pending (wm_pending),
    .level   (wm_level)
);

// File: tb/uart_tx_wm_test.sv
module uart_tx_wm_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] ctrl = '0;
    logic        int_en = 1'b0;
    logic [15:0] divisor = 16'd3;
    logic        txd, wm_pending, irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string cur_req = "R1";

    logic [7:0] q[$];
    bit         m_busy = 0;
    bit         m_txd = 1;
    int         m_pos = 0;
    int         m_tick = 0;
    logic [7:0] m_cur = '0;

    always #5 clk = ~clk;

    uart_tx_wm uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ctrl(ctrl), .int_en(int_en), .divisor(divisor),
        .txd(txd), .wm_pending(wm_pending), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cycles, act, exp);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            q.delete();
            m_busy = 0; m_txd = 1; m_pos = 0; m_tick = 0;
        end else begin
            bit do_push;
            do_push = wr_en && (q.size() < 8);
            if (!m_busy) begin
                if (ctrl[0] && q.size() > 0) begin
                    m_cur = q.pop_front(); m_busy = 1; m_pos = 0; m_tick = 0; m_txd = 0;
                end else m_txd = 1;
            end else if (m_tick == int'(divisor)) begin
                m_tick = 0;
                m_pos++;
                if (m_pos <= 8) m_txd = m_cur[m_pos-1];
                else if (m_pos == 9 || (m_pos == 10 && ctrl[1])) m_txd = 1;
                else if (ctrl[0] && q.size() > 0) begin
                    m_cur = q.pop_front(); m_pos = 0; m_txd = 0;
                end else begin
                    m_busy = 0; m_txd = 1;
                end
            end else m_tick++;
            if (do_push) q.push_back(wr_data[7:0]);
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (cycles > 0) begin
            bit exp_pend;
            exp_pend = (q.size() < int'(ctrl[18:16]));
            check({cur_req, "/R2 txd"}, {31'b0, txd}, {31'b0, m_txd});
            check({cur_req, "/R5 status"}, rd_data, {(q.size() == 8), 31'b0});
            check({cur_req, "/R7 pending"}, {31'b0, wm_pending}, {31'b0, exp_pend});
            check({cur_req, "/R8 irq"}, {31'b0, irq}, {31'b0, exp_pend && int_en});
        end
        if (cycles > 150000) begin
            bad++;
            $display("FAIL watchdog: run did not end");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic burst(int n, logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wr_en = 1'b1;
            wr_data = {24'hABCDEF, base + 8'(i * 37)};
        end
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while ((q.size() > 0 || m_busy) && guard < 20000) begin
            @(posedge clk); guard++;
        end
        #1;
    endtask

    initial begin
        ctrl = 32'h0000_0000;
        idle(3);
        @(negedge clk);
        check("R1 txd at reset", {31'b0, txd}, 32'd1);
        check("R1 status at reset", rd_data, 32'd0);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R2";
        ctrl = 32'h0001_0001; int_en = 1'b1; divisor = 16'd3;
        burst(1, 8'hA5);
        drain(); idle(4);
        burst(1, 8'h01);
        drain(); idle(4);

        cur_req = "R3";
        ctrl = 32'h0001_0003;
        burst(1, 8'h3C);
        drain(); idle(3);

        cur_req = "R11";
        burst(3, 8'h81);
        drain(); idle(3);

        cur_req = "R6";
        ctrl = 32'h0007_0000;
        burst(11, 8'h10);
        @(negedge clk);
        check("R5 full flag after overrun", {31'b0, rd_data[31]}, 32'd1);
        check("R6 no pending at level 7 with 8 queued", {31'b0, wm_pending}, 32'd0);
        #1;
        cur_req = "R10";
        idle(40);
        @(negedge clk);
        check("R10 line stays idle while disabled", {31'b0, txd}, 32'd1);
        #1;

        cur_req = "R7";
        ctrl = 32'h0004_0001;
        drain(); idle(3);

        cur_req = "R9";
        ctrl = 32'h0001_0001;
        burst(2, 8'h5A);
        drain(); idle(3);

        cur_req = "R2";
        divisor = 16'd0;
        ctrl = 32'h0003_0001;
        burst(5, 8'hC3);
        drain(); idle(3);

        cur_req = "R10";
        divisor = 16'd2;
        burst(3, 8'h77);
        idle(6);
        ctrl = 32'h0003_0000;
        idle(60);
        @(negedge clk);
        check("R10 line idle after stop with bytes queued", {31'b0, txd}, 32'd1);
        #1;
        ctrl = 32'h0003_0001;
        drain(); idle(3);

        cur_req = "R8";
        int_en = 1'b0;
        ctrl = 32'h0005_0001;
        burst(2, 8'h99);
        drain(); idle(3);
        ctrl = 32'h0000_0001; int_en = 1'b1;
        idle(3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule